// File: doc/BRIEF.md
# Thread Flush Trigger and Timeout Monitor

This block decides, per hardware thread, when a thread must be flushed so that the shared pipeline resources it holds are released to the other threads. It watches three kinds of event. The first is a load that missed the last-level cache. The second is an IO access reaching commit. The third is the oldest uncommitted load or store of a thread that has sat without committing for a programmable number of cycles. The age check catches stalls the other two triggers cannot see, such as a load that waits on forwarding from an older store that itself missed the cache.

For every thread the block emits a one-cycle flush pulse together with a two-bit cause code, one register stage after the triggering event. Pulses for different threads are independent and may coincide. When several triggers hit one thread in the same cycle, only one pulse is issued and the cause code names the highest-priority trigger. The flush itself, the caches and the refetch belong to other blocks.

Each thread presents its current oldest memory operation as a valid bit and a tag. A new tag, or a valid bit that has just risen, starts a fresh age count. A commit of that operation stops the count, and so does any flush of the thread.

Top module: `thread_flush_gen`

## Requirements
- R1: A cache-miss event (`l3_miss_vld` with thread `l3_miss_tid`) makes `flush_pls[t]` high in the cycle after the event, with cause code 2'b01 in `flush_cause[2t+1:2t]`.
- R2: An IO commit event (`io_cmt_vld` with thread `io_cmt_tid`) makes `flush_pls[t]` high in the cycle after the event, with cause code 2'b10.
- R3: An oldest memory operation is first seen on a rising edge. If it stays presented with the same tag and without commit through that edge and the following `tmo_limit` edges, a flush with cause code 2'b11 is registered on the last of those edges.
- R4: A commit of the oldest memory operation (`mem_cmt_vld`, `mem_cmt_tid`) stops its age count. That operation then never times out, even when the commit falls in the cycle where the timeout would otherwise fire.
- R5: A change of the oldest tag restarts the age count from the cycle of the change.
- R6: When triggers coincide on one thread, exactly one pulse is issued, with priority cache miss over IO over age timeout.
- R7: After any flush of a thread, its age check stays idle until a new oldest operation is presented. Holding the same tag produces no further pulse.
- R8: Flush decisions for different threads are independent, and their pulses may be high in the same cycle.
- R9: A `tmo_limit` of zero disables the age timeout.
- R10: During and after reset all pulses are low and all cause codes are 2'b00. A thread with no flush shows pulse low and cause 2'b00.
- R11: Dropping `oldest_vld[t]` clears that thread's age count. Presenting the operation again, even with the same tag, counts as a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_limit | input | CNT_W | Age limit in cycles; zero disables the timeout |
| l3_miss_vld | input | 1 | A load missed the last-level cache this cycle |
| l3_miss_tid | input | TID_W | Thread of the missing load |
| io_cmt_vld | input | 1 | An IO access reached commit this cycle |
| io_cmt_tid | input | TID_W | Thread of the IO access |
| mem_cmt_vld | input | 1 | The oldest memory operation of a thread committed |
| mem_cmt_tid | input | TID_W | Thread of that commit |
| oldest_vld | input | NUM_THR | Per thread: an oldest uncommitted load or store exists |
| oldest_tag | input | NUM_THR*TAG_W | Per thread tag of that operation, thread t in bits [t*TAG_W +: TAG_W] |
| flush_pls | output | NUM_THR | One-cycle flush request per thread |
| flush_cause | output | 2*NUM_THR | Cause per thread in bits [2t+1:2t]: 00 none, 01 cache miss, 10 IO, 11 age |

## Verification
A stale "armed" flag or age count would show up as a missing or extra age pulse. If the tag comparison or the clearing after commit, flush or a dropped valid bit goes wrong, the pulse moves away from the expected edge, by as many cycles as the count is off, or it repeats while a tag is held. A wrong priority or decode shows up in the same cycle as a wrong cause code or a pulse on the wrong thread. Because every output is checked in every cycle, an error surfaces at most `tmo_limit` plus one cycles after the state first diverges.

// File: rtl/tfg_pkg.sv
package tfg_pkg;

   // flush cause code, one field per thread on the output bus
   typedef enum logic [1:0] {
      FC_NONE   = 2'd0,
      FC_L3MISS = 2'd1,
      FC_IO     = 2'd2,
      FC_AGE    = 2'd3
   } flush_cause_e;

   localparam int CAUSE_W = 2;

endpackage

// File: rtl/tfg_tid_dec.sv
// Turns a thread-tagged event strobe into a per-thread hit vector.
module tfg_tid_dec #(
   parameter int NUM_THR = 4,
   parameter int TID_W   = 2
) (
   input  logic               evt_vld,
   input  logic [TID_W-1:0]   evt_tid,
   output logic [NUM_THR-1:0] thr_hit
);

   generate
      if (TID_W < 1) begin : g_bad_w
         $error("tfg_tid_dec: TID_W must be at least 1");
      end
      if (NUM_THR > (1 << TID_W)) begin : g_bad_n
         $error("tfg_tid_dec: TID_W too narrow for NUM_THR");
      end
   endgenerate

   for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
      assign thr_hit[g] = evt_vld && (evt_tid == TID_W'(g));
   end

endmodule

// File: rtl/tfg_age_timer.sv
// Per-thread age counter for the oldest uncommitted memory operation.
module tfg_age_timer #(
   parameter int TAG_W = 6,
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_vld,
   input  logic [TAG_W-1:0] op_tag,
   input  logic             op_cmt,
   input  logic             flush_fire,
   input  logic [CNT_W-1:0] limit,
   output logic             age_hit
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (TAG_W < 1) begin : g_bad_tag
         $error("tfg_age_timer: TAG_W must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("tfg_age_timer: CNT_W must be at least 2");
      end
   endgenerate

   logic             seen_vld;
   logic [TAG_W-1:0] seen_tag;
   logic             armed;
   logic [CNT_W-1:0] age;
   logic             new_op;

   // a fresh oldest operation: valid just rose or the tag moved on
   assign new_op  = op_vld && (!seen_vld || (op_tag != seen_tag));

   assign age_hit = armed && op_vld && !new_op && !op_cmt &&
                    (limit != '0) && (age >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_vld <= 1'b0;
         seen_tag <= '0;
      end else begin
         seen_vld <= op_vld;
         seen_tag <= op_tag;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         age   <= '0;
      end else if (flush_fire) begin
         armed <= 1'b0;
         age   <= '0;
      end else if (new_op) begin
         armed <= 1'b1;
         age   <= CNT_ONE;
      end else if (!op_vld || op_cmt) begin
         armed <= 1'b0;
         age   <= '0;
      end else if (armed && (age != CNT_MAX)) begin
         age   <= age + CNT_ONE;
      end
   end

   AST_AGE_OFF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (limit == '0) |-> !age_hit);                                       // R9
   AST_AGE_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      age_hit |=> !age_hit);                                             // R7
   AST_COMMIT_STOPS_AGE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_cmt && !new_op) |=> !age_hit);                                 // R4
   AST_DROP_STOPS_AGE: assert property (@(posedge clk) disable iff (!rst_n)
      !op_vld |=> !age_hit);                                             // R11

endmodule

// File: rtl/tfg_cause_pick.sv
// Priority merge of the three flush triggers of one thread.
module tfg_cause_pick
   import tfg_pkg::*;
(
   input  logic         l3_hit,
   input  logic         io_hit,
   input  logic         age_hit,
   output logic         fire,
   output flush_cause_e cause
);

   assign fire = l3_hit || io_hit || age_hit;

   always_comb begin
      if (l3_hit)       cause = FC_L3MISS;
      else if (io_hit)  cause = FC_IO;
      else if (age_hit) cause = FC_AGE;
      else              cause = FC_NONE;
   end

endmodule

// File: rtl/thread_flush_gen.sv
module thread_flush_gen
   import tfg_pkg::*;
#(
   parameter int NUM_THR = 4,
   parameter int TAG_W   = 6,
   parameter int CNT_W   = 12,
   parameter bit OUT_REG = 1'b1,
   localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [CNT_W-1:0]         tmo_limit,
   input  logic                     l3_miss_vld,
   input  logic [TID_W-1:0]         l3_miss_tid,
   input  logic                     io_cmt_vld,
   input  logic [TID_W-1:0]         io_cmt_tid,
   input  logic                     mem_cmt_vld,
   input  logic [TID_W-1:0]         mem_cmt_tid,
   input  logic [NUM_THR-1:0]       oldest_vld,
   input  logic [NUM_THR*TAG_W-1:0] oldest_tag,
   output logic [NUM_THR-1:0]       flush_pls,
   output logic [NUM_THR*CAUSE_W-1:0] flush_cause
);

   localparam int CBUS_W = NUM_THR * CAUSE_W;

   generate
      if (NUM_THR < 2) begin : g_bad_thr
         $error("thread_flush_gen: NUM_THR must be at least 2");
      end
   endgenerate

   logic [NUM_THR-1:0] l3_hit;
   logic [NUM_THR-1:0] io_hit;
   logic [NUM_THR-1:0] cmt_hit;
   logic [NUM_THR-1:0] age_hit;
   logic [NUM_THR-1:0] fire;
   logic [CBUS_W-1:0]  cause_bus;

   // event decode, one decoder per trigger source
   tfg_tid_dec #(.NUM_THR(NUM_THR), .TID_W(TID_W)) u_dec_l3 (
      .evt_vld(l3_miss_vld), .evt_tid(l3_miss_tid), .thr_hit(l3_hit));
   tfg_tid_dec #(.NUM_THR(NUM_THR), .TID_W(TID_W)) u_dec_io (
      .evt_vld(io_cmt_vld),  .evt_tid(io_cmt_tid),  .thr_hit(io_hit));
   tfg_tid_dec #(.NUM_THR(NUM_THR), .TID_W(TID_W)) u_dec_cmt (
      .evt_vld(mem_cmt_vld), .evt_tid(mem_cmt_tid), .thr_hit(cmt_hit));

   // per-thread age check and cause selection
   for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
      flush_cause_e thr_cause;

      tfg_age_timer #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_age (
         .clk       (clk),
         .rst_n     (rst_n),
         .op_vld    (oldest_vld[g]),
         .op_tag    (oldest_tag[g*TAG_W +: TAG_W]),
         .op_cmt    (cmt_hit[g]),
         .flush_fire(fire[g]),
         .limit     (tmo_limit),
         .age_hit   (age_hit[g])
      );

      tfg_cause_pick u_pick (
         .l3_hit (l3_hit[g]),
         .io_hit (io_hit[g]),
         .age_hit(age_hit[g]),
         .fire   (fire[g]),
         .cause  (thr_cause)
      );

      assign cause_bus[g*CAUSE_W +: CAUSE_W] = thr_cause;
   end

   // output stage: registered by default, a pass-through variant on request
   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flush_pls   <= '0;
               flush_cause <= '0;
            end else begin
               flush_pls   <= fire;
               flush_cause <= cause_bus;
            end
         end

         for (genvar a = 0; a < NUM_THR; a++) begin : g_chk
            AST_L3_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
               l3_hit[a] |=> (flush_pls[a] &&
                  (flush_cause[a*CAUSE_W +: CAUSE_W] == FC_L3MISS)));           // R1
            AST_IO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
               (io_hit[a] && !l3_hit[a]) |=> (flush_pls[a] &&
                  (flush_cause[a*CAUSE_W +: CAUSE_W] == FC_IO)));               // R2
            AST_AGE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
               (age_hit[a] && !l3_hit[a] && !io_hit[a]) |=>
                  (flush_cause[a*CAUSE_W +: CAUSE_W] == FC_AGE));               // R6
            AST_QUIET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
               !flush_pls[a] |-> (flush_cause[a*CAUSE_W +: CAUSE_W] == FC_NONE)); // R10
         end
      end else begin : g_out_comb
         assign flush_pls   = fire;
         assign flush_cause = cause_bus;
      end
   endgenerate

endmodule

// File: tb/thread_flush_gen_test.sv
module thread_flush_gen_test;

   localparam int NT = 4;
   localparam int TW = 4;
   localparam int CW = 8;
   localparam int CB = 2 * NT;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [CW-1:0]    lim = CW'(5);
   logic             l3v = 1'b0, iov = 1'b0, cmv = 1'b0;
   logic [1:0]       l3t = '0, iot = '0, cmt = '0;
   logic [NT-1:0]    ovld = '0;
   logic [NT*TW-1:0] otag = '0;
   logic [NT-1:0]    fpl;
   logic [CB-1:0]    fca;

   typedef struct {
      logic [NT-1:0] fl;
      logic [CB-1:0] ca;
      string         rq;
   } exp_t;

   exp_t sb[$];
   int   vec = 0;
   int   bad = 0;

   thread_flush_gen #(.NUM_THR(NT), .TAG_W(TW), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .tmo_limit(lim),
      .l3_miss_vld(l3v), .l3_miss_tid(l3t),
      .io_cmt_vld(iov), .io_cmt_tid(iot),
      .mem_cmt_vld(cmv), .mem_cmt_tid(cmt),
      .oldest_vld(ovld), .oldest_tag(otag),
      .flush_pls(fpl), .flush_cause(fca));

   // cause code c placed in the field of thread t
   function automatic logic [CB-1:0] mk(int t, int c);
      return CB'(c) << (2 * t);
   endfunction

   // drives one cycle of events and queues the outputs expected after the next edge
   task automatic drive(logic lv, int lt, logic iv, int it, logic cv, int ct,
                        logic [NT-1:0] efl, logic [CB-1:0] eca, string rq);
      exp_t e;
      l3v = lv; l3t = 2'(lt);
      iov = iv; iot = 2'(it);
      cmv = cv; cmt = 2'(ct);
      e.fl = efl; e.ca = eca; e.rq = rq;
      sb.push_back(e);
      @(negedge clk);
   endtask

   task automatic quiet(int n, string rq);
      repeat (n) drive(1'b0, 0, 1'b0, 0, 1'b0, 0, '0, '0, rq);
   endtask

   task automatic set_op(int t, logic v, int tg);
      ovld[t] = v;
      otag[t*TW +: TW] = TW'(tg);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
   endtask

   // monitor: compares each queued expectation in the middle of the high phase
   always @(posedge clk) begin
      exp_t e;
      #5;
      if (sb.size() != 0) begin
         e = sb.pop_front();
         vec++;
         if (fpl !== e.fl || fca !== e.ca) begin
            bad++;
            $display("FAIL %s: flush=%b cause=%b, expected flush=%b cause=%b",
                     e.rq, fpl, fca, e.fl, e.ca);
         end
      end
   end

   initial begin
      #400000;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      vec++;
      if (fpl !== '0 || fca !== '0) begin
         bad++;
         $display("FAIL R10 reset: flush=%b cause=%b, expected flush=0 cause=0", fpl, fca);
      end
      rst_n = 1'b1;
      quiet(2, "R10 idle after reset");

      // R1 cache miss on thread 2
      drive(1'b1, 2, 1'b0, 0, 1'b0, 0, 4'b0100, mk(2, 1), "R1");
      quiet(1, "R10 pulse lasts one cycle");
      // R2 IO commit on thread 1
      drive(1'b0, 0, 1'b1, 1, 1'b0, 0, 4'b0010, mk(1, 2), "R2");
      quiet(1, "R10");
      // R6 miss and IO on the same thread: single pulse, miss wins
      drive(1'b1, 3, 1'b1, 3, 1'b0, 0, 4'b1000, mk(3, 1), "R6");
      quiet(1, "R6");
      // R8 miss on thread 0 and IO on thread 3 together
      drive(1'b1, 0, 1'b1, 3, 1'b0, 0, 4'b1001, mk(0, 1) | mk(3, 2), "R8");
      quiet(1, "R8");

      // R3 age timeout on thread 0, then R7 no repeat while tag held
      set_op(0, 1'b1, 3);
      quiet(5, "R3 before limit");
      drive(1'b0, 0, 1'b0, 0, 1'b0, 0, 4'b0001, mk(0, 3), "R3");
      quiet(8, "R7");
      set_op(0, 1'b0, 0);

      // R4 commit in the cycle the timeout would fire
      set_op(1, 1'b1, 2);
      quiet(5, "R4");
      drive(1'b0, 0, 1'b0, 0, 1'b1, 1, '0, '0, "R4 commit on firing cycle");
      quiet(8, "R4 no timeout after commit");
      // R5 a tag change restarts the count
      set_op(1, 1'b1, 7);
      quiet(4, "R5");
      set_op(1, 1'b1, 9);
      quiet(5, "R5 restarted");
      drive(1'b0, 0, 1'b0, 0, 1'b0, 0, 4'b0010, mk(1, 3), "R5");
      set_op(1, 1'b0, 0);
      quiet(1, "R5");

      // R8 two threads time out in the same cycle
      set_op(0, 1'b1, 1);
      set_op(1, 1'b1, 1);
      quiet(5, "R8");
      drive(1'b0, 0, 1'b0, 0, 1'b0, 0, 4'b0011, mk(0, 3) | mk(1, 3), "R8");
      set_op(0, 1'b0, 0);
      set_op(1, 1'b0, 0);
      quiet(1, "R8");

      // R11 valid drop clears the count; same tag again counts as new
      set_op(2, 1'b1, 4);
      quiet(3, "R11");
      set_op(2, 1'b0, 4);
      quiet(2, "R11");
      set_op(2, 1'b1, 4);
      quiet(5, "R11 restarted");
      drive(1'b0, 0, 1'b0, 0, 1'b0, 0, 4'b0100, mk(2, 3), "R11");
      set_op(2, 1'b0, 0);
      quiet(1, "R11");

      // R6 miss in the timeout cycle wins, R7 flush leaves the check idle
      set_op(3, 1'b1, 5);
      quiet(5, "R6");
      drive(1'b1, 3, 1'b0, 0, 1'b0, 0, 4'b1000, mk(3, 1), "R6");
      quiet(8, "R7 idle after miss flush");
      set_op(3, 1'b0, 0);

      // R9 zero limit disables the timeout
      lim = '0;
      set_op(2, 1'b1, 6);
      quiet(20, "R9");
      set_op(2, 1'b0, 0);
      quiet(1, "R9");
      lim = CW'(5);
      quiet(2, "R10");

      while (sb.size() != 0) @(negedge clk);
      summary();
      $finish;
   end

endmodule